// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a TFT display from programmable field values. A divider turns the system clock into a pixel-rate enable and a square pixel clock. Each line steps through four phases (sync pulse, back porch, active pixels and front porch). The frame steps through the same four phases counted in whole lines. The block drives horizontal sync, vertical sync, data enable, an optional line-end pulse, gated pixel data and the pixel clock. Each of these outputs has its own polarity control.

A downstream pixel source follows the raster through three outputs: an active-pixel strobe, the x/y position inside the visible area, and the phase status codes. The status outputs also carry a line counter that runs down over the visible lines. Every length field counts as its value plus one. The geometry fields and the line-end enable are copied into shadow storage only at a frame boundary, or while video is off. A write in the middle of a frame therefore takes effect from the next frame.

Top module: `tft_timing_gen`

## Requirements
- R1: The pixel clock period is 2*(clk_div+1) system clocks, and a clk_div of 0 acts as 1. The pixel clock is low for the first clk_div+1 cycles after an enable or a period boundary, then high. With edge_sel=1 it is inverted, so pixel state changes on its rising edge instead of its falling edge.
- R2: Each line is made of h_sync_len+1, h_back_len+1, h_act_len+1 and h_front_len+1 pixel periods, in that order. hsync is active during the first group.
- R3: Each frame is made of v_sync_len+1, v_back_len+1, v_act_len+1 and v_front_len+1 lines, in that order. vsync is active for the whole of the first group.
- R4: hstat_o and vstat_o report the current phase as 2'b00 sync, 2'b01 back porch, 2'b10 active and 2'b11 front porch.
- R5: line_cnt_o shows v_act_len during vertical sync and back porch. During active line k (from 0) it shows v_act_len-k. During the front porch it shows 0.
- R6: de is active only when both phases are active. pix_stb_o pulses for one system clock at the end of each active pixel period. x_o and y_o give the position inside the active area and are 0 outside it.
- R7: Each of hsync, vsync, de, lend and pix_o is XORed with its own invert input. pix_o carries pix_in while de is active and 0 otherwise, before that XOR.
- R8: lend is active during the last pixel period of every line, and only if lend_en was set when the frame started.
- R9: While vid_en is 0, every output sits at its inactive level, and pclk_o sits at edge_sel. Re-enabling restarts at the first pixel of horizontal and vertical sync.
- R10: The geometry fields and lend_en are taken at the end of the last pixel of a frame, or while vid_en is 0. Changes made mid-frame do not alter the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_en | input | 1 | Video timing enable |
| clk_div | input | DIV_W | Pixel clock divide value |
| edge_sel | input | 1 | Pixel clock edge select |
| h_sync_len | input | H_SYNC_W | Horizontal sync width minus one |
| h_back_len | input | H_BACK_W | Horizontal back porch minus one |
| h_act_len | input | H_ACT_W | Active pixels per line minus one |
| h_front_len | input | H_FRONT_W | Horizontal front porch minus one |
| v_sync_len | input | V_SYNC_W | Vertical sync lines minus one |
| v_back_len | input | V_BACK_W | Vertical back porch lines minus one |
| v_act_len | input | V_ACT_W | Active lines minus one |
| v_front_len | input | V_FRONT_W | Vertical front porch lines minus one |
| lend_en | input | 1 | Line-end pulse enable |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data enable |
| inv_lend | input | 1 | Invert line-end pulse |
| inv_data | input | 1 | Invert pixel data |
| pix_in | input | PIX_W | Pixel data from the source |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| lend_o | output | 1 | Line-end pulse |
| pix_o | output | PIX_W | Gated pixel data |
| pix_stb_o | output | 1 | Active pixel strobe |
| x_o | output | H_ACT_W | Active pixel column |
| y_o | output | V_ACT_W | Active line row |
| hstat_o | output | 2 | Horizontal phase code |
| vstat_o | output | 2 | Vertical phase code |
| line_cnt_o | output | V_ACT_W | Down-counting line counter |

## Verification
The bench builds the block with the default field widths and a 12-bit pixel bus. It programs small geometries, so that a full frame lasts under 800 system clocks. Within the run time this fits several complete frames, a change of geometry in mid-frame that must wait for the boundary, and divide values of 0, 1 and 3. Wide field values are left to the arithmetic, which is identical at any width. A model computes every output from the elapsed pixel count. Counting the sync widths and the strobes per frame also checks the phase lengths directly.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'b00,
    PH_BACK  = 2'b01,
    PH_ACT   = 2'b10,
    PH_FRONT = 2'b11
  } tft_phase_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic tft_phase_e next_phase(input tft_phase_e p);
    return tft_phase_e'(p + 2'd1);
  endfunction

endpackage

// File: rtl/tft_pclk_div.sv
module tft_pclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             lvl
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             half_end;

  assign div_eff  = (div_val < DIV_MIN) ? DIV_MIN : div_val;
  assign half_end = (cnt >= div_eff);
  assign tick     = half_end & lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/tft_phase_seq.sv
module tft_phase_seq
  import tft_timing_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output tft_phase_e   phase,
  output logic [W-1:0] pos,
  output logic         last
);
  logic [W-1:0] cur_len;
  logic         seg_end;

  always_comb begin
    unique case (phase)
      PH_SYNC:  cur_len = len_sync;
      PH_BACK:  cur_len = len_back;
      PH_ACT:   cur_len = len_act;
      default:  cur_len = len_front;
    endcase
  end

  assign seg_end = (pos == cur_len);
  assign last    = seg_end && (phase == PH_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      pos   <= '0;
    end else if (clr) begin
      phase <= PH_SYNC;
      pos   <= '0;
    end else if (step) begin
      if (seg_end) begin
        pos   <= '0;
        phase <= next_phase(phase);
      end else begin
        pos <= pos + W'(1);
      end
    end
  end

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int H_SYNC_W  = 8,
  parameter int H_BACK_W  = 7,
  parameter int H_ACT_W   = 11,
  parameter int H_FRONT_W = 8,
  parameter int V_SYNC_W  = 6,
  parameter int V_BACK_W  = 8,
  parameter int V_ACT_W   = 10,
  parameter int V_FRONT_W = 8,
  parameter int PIX_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vid_en,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic                 edge_sel,
  input  logic [H_SYNC_W-1:0]  h_sync_len,
  input  logic [H_BACK_W-1:0]  h_back_len,
  input  logic [H_ACT_W-1:0]   h_act_len,
  input  logic [H_FRONT_W-1:0] h_front_len,
  input  logic [V_SYNC_W-1:0]  v_sync_len,
  input  logic [V_BACK_W-1:0]  v_back_len,
  input  logic [V_ACT_W-1:0]   v_act_len,
  input  logic [V_FRONT_W-1:0] v_front_len,
  input  logic                 lend_en,
  input  logic                 inv_hsync,
  input  logic                 inv_vsync,
  input  logic                 inv_de,
  input  logic                 inv_lend,
  input  logic                 inv_data,
  input  logic [PIX_W-1:0]     pix_in,
  output logic                 pclk_o,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 de_o,
  output logic                 lend_o,
  output logic [PIX_W-1:0]     pix_o,
  output logic                 pix_stb_o,
  output logic [H_ACT_W-1:0]   x_o,
  output logic [V_ACT_W-1:0]   y_o,
  output logic [1:0]           hstat_o,
  output logic [1:0]           vstat_o,
  output logic [V_ACT_W-1:0]   line_cnt_o
);
  localparam int HW = max4(H_SYNC_W, H_BACK_W, H_ACT_W, H_FRONT_W);
  localparam int VW = max4(V_SYNC_W, V_BACK_W, V_ACT_W, V_FRONT_W);

  // shadow copies of the geometry, refreshed only at frame boundaries
  logic [H_SYNC_W-1:0]  sh_h_sync;
  logic [H_BACK_W-1:0]  sh_h_back;
  logic [H_ACT_W-1:0]   sh_h_act;
  logic [H_FRONT_W-1:0] sh_h_front;
  logic [V_SYNC_W-1:0]  sh_v_sync;
  logic [V_BACK_W-1:0]  sh_v_back;
  logic [V_ACT_W-1:0]   sh_v_act;
  logic [V_FRONT_W-1:0] sh_v_front;
  logic                 sh_lend_en;

  // named internal events
  logic       clr;
  logic       tick;
  logic       pclk_lvl;
  logic       h_last;
  logic       v_last;
  logic       v_step;
  logic       frame_end;
  logic       shadow_load;
  logic       hs_int, vs_int, de_int, le_int;
  tft_phase_e h_ph, v_ph;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  assign clr         = !vid_en;
  assign v_step      = tick && h_last;
  assign frame_end   = v_step && v_last;
  assign shadow_load = clr || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_h_sync  <= '0;
      sh_h_back  <= '0;
      sh_h_act   <= '0;
      sh_h_front <= '0;
      sh_v_sync  <= '0;
      sh_v_back  <= '0;
      sh_v_act   <= '0;
      sh_v_front <= '0;
      sh_lend_en <= 1'b0;
    end else if (shadow_load) begin
      sh_h_sync  <= h_sync_len;
      sh_h_back  <= h_back_len;
      sh_h_act   <= h_act_len;
      sh_h_front <= h_front_len;
      sh_v_sync  <= v_sync_len;
      sh_v_back  <= v_back_len;
      sh_v_act   <= v_act_len;
      sh_v_front <= v_front_len;
      sh_lend_en <= lend_en;
    end
  end

  tft_pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .div_val (clk_div),
    .tick    (tick),
    .lvl     (pclk_lvl)
  );

  tft_phase_seq #(.W(HW)) u_hseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .step      (tick),
    .len_sync  (HW'(sh_h_sync)),
    .len_back  (HW'(sh_h_back)),
    .len_act   (HW'(sh_h_act)),
    .len_front (HW'(sh_h_front)),
    .phase     (h_ph),
    .pos       (h_pos),
    .last      (h_last)
  );

  tft_phase_seq #(.W(VW)) u_vseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .step      (v_step),
    .len_sync  (VW'(sh_v_sync)),
    .len_back  (VW'(sh_v_back)),
    .len_act   (VW'(sh_v_act)),
    .len_front (VW'(sh_v_front)),
    .phase     (v_ph),
    .pos       (v_pos),
    .last      (v_last)
  );

  assign hs_int = vid_en && (h_ph == PH_SYNC);
  assign vs_int = vid_en && (v_ph == PH_SYNC);
  assign de_int = vid_en && (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign le_int = vid_en && sh_lend_en && h_last;

  assign pclk_o    = (vid_en & pclk_lvl) ^ edge_sel;
  assign hsync_o   = hs_int ^ inv_hsync;
  assign vsync_o   = vs_int ^ inv_vsync;
  assign de_o      = de_int ^ inv_de;
  assign lend_o    = le_int ^ inv_lend;
  assign pix_o     = (de_int ? pix_in : '0) ^ {PIX_W{inv_data}};
  assign pix_stb_o = tick && de_int;

  assign x_o     = (h_ph == PH_ACT) ? h_pos[H_ACT_W-1:0] : '0;
  assign y_o     = (v_ph == PH_ACT) ? v_pos[V_ACT_W-1:0] : '0;
  assign hstat_o = h_ph;
  assign vstat_o = v_ph;

  always_comb begin
    unique case (v_ph)
      PH_SYNC, PH_BACK: line_cnt_o = sh_v_act;
      PH_ACT:           line_cnt_o = sh_v_act - v_pos[V_ACT_W-1:0];
      default:          line_cnt_o = '0;
    endcase
  end

endmodule

// File: rtl/tft_timing_chk.sv
module tft_timing_chk #(
  parameter int DIV_W   = 10,
  parameter int H_ACT_W = 11,
  parameter int V_ACT_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vid_en,
  input logic [DIV_W-1:0]   clk_div,
  input logic               tick,
  input logic               le_int,
  input logic               frame_end,
  input logic [1:0]         hstat,
  input logic [V_ACT_W-1:0] line_cnt,
  input logic [H_ACT_W-1:0] sh_h_act,
  input logic [V_ACT_W-1:0] sh_v_act,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               de_o,
  input logic               lend_o,
  input logic               inv_hsync,
  input logic               inv_vsync,
  input logic               inv_de,
  input logic               inv_lend
);
  logic [DIV_W+1:0] gap;
  logic             armed;
  logic [DIV_W-1:0] prev_div;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      armed    <= 1'b0;
      prev_div <= '0;
    end else begin
      prev_div <= clk_div;
      gap      <= tick ? '0 : gap + (DIV_W+2)'(1);
      if (!vid_en || clk_div != prev_div) armed <= 1'b0;
      else if (tick) armed <= 1'b1;
    end
  end

  // R1: successive pixel ticks are 2*(div+1) system clocks apart
  a_r1_pixel_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && vid_en && clk_div == prev_div) |-> (gap == (DIV_W+2)'({div_eff, 1'b1})));

  // R4: the horizontal phase code only advances by one step
  a_r4_hphase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && $past(vid_en) && hstat != $past(hstat)) |-> (hstat == 2'($past(hstat) + 2'd1)));

  // R5: the line counter only ever decrements, except when reloading from 0
  a_r5_linecnt_down: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && $past(vid_en) && line_cnt != $past(line_cnt) && $past(line_cnt) != '0)
      |-> (line_cnt == V_ACT_W'($past(line_cnt) - 1'b1)));

  // R8: the line-end pulse is followed by the start of a new line
  a_r8_lend_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (le_int && tick) |=> (hstat == 2'b00));

  // R9: disabled video holds every timing output at its inactive level
  a_r9_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_en |-> (hsync_o == inv_hsync && vsync_o == inv_vsync && de_o == inv_de && lend_o == inv_lend));

  // R10: the geometry in use does not change inside a frame
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && $past(vid_en) && !$past(frame_end)) |-> ($stable(sh_h_act) && $stable(sh_v_act)));

endmodule

bind tft_timing_gen tft_timing_chk #(
  .DIV_W   (DIV_W),
  .H_ACT_W (H_ACT_W),
  .V_ACT_W (V_ACT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vid_en    (vid_en),
  .clk_div   (clk_div),
  .tick      (tick),
  .le_int    (le_int),
  .frame_end (frame_end),
  .hstat     (hstat_o),
  .line_cnt  (line_cnt_o),
  .sh_h_act  (sh_h_act),
  .sh_v_act  (sh_v_act),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .lend_o    (lend_o),
  .inv_hsync (inv_hsync),
  .inv_vsync (inv_vsync),
  .inv_de    (inv_de),
  .inv_lend  (inv_lend)
);

// File: tb/sim_tft_timing_gen.sv
`timescale 1ns/100ps
module sim_tft_timing_gen;
  localparam int DIV_W = 10, H_SYNC_W = 8, H_BACK_W = 7, H_ACT_W = 11, H_FRONT_W = 8;
  localparam int V_SYNC_W = 6, V_BACK_W = 8, V_ACT_W = 10, V_FRONT_W = 8, PIX_W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, vid_en, edge_sel, lend_en;
  logic inv_hsync, inv_vsync, inv_de, inv_lend, inv_data;
  logic [DIV_W-1:0] clk_div;
  logic [H_SYNC_W-1:0] h_sync_len;
  logic [H_BACK_W-1:0] h_back_len;
  logic [H_ACT_W-1:0] h_act_len;
  logic [H_FRONT_W-1:0] h_front_len;
  logic [V_SYNC_W-1:0] v_sync_len;
  logic [V_BACK_W-1:0] v_back_len;
  logic [V_ACT_W-1:0] v_act_len;
  logic [V_FRONT_W-1:0] v_front_len;
  logic [PIX_W-1:0] pix_in;
  logic pclk_o, hsync_o, vsync_o, de_o, lend_o, pix_stb_o;
  logic [PIX_W-1:0] pix_o;
  logic [H_ACT_W-1:0] x_o;
  logic [V_ACT_W-1:0] y_o;
  logic [1:0] hstat_o, vstat_o;
  logic [V_ACT_W-1:0] line_cnt_o;

  tft_timing_gen #(.PIX_W(PIX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .clk_div(clk_div), .edge_sel(edge_sel),
    .h_sync_len(h_sync_len), .h_back_len(h_back_len), .h_act_len(h_act_len),
    .h_front_len(h_front_len), .v_sync_len(v_sync_len), .v_back_len(v_back_len),
    .v_act_len(v_act_len), .v_front_len(v_front_len), .lend_en(lend_en),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de), .inv_lend(inv_lend),
    .inv_data(inv_data), .pix_in(pix_in), .pclk_o(pclk_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .lend_o(lend_o), .pix_o(pix_o), .pix_stb_o(pix_stb_o),
    .x_o(x_o), .y_o(y_o), .hstat_o(hstat_o), .vstat_o(vstat_o), .line_cnt_o(line_cnt_o)
  );

  int checks = 0;
  int errors = 0;
  string scen = "init";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual %0d expected %0d", req, scen, what, act, exp);
    end
  endtask

  // reference model: elapsed system clocks in the frame plus the geometry in use
  int s;
  int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf;
  bit m_le;

  function automatic int period();
    int cv;
    cv = (clk_div < 1) ? 1 : int'(clk_div);
    return 2 * (cv + 1);
  endfunction

  task automatic take_geometry();
    m_hs = h_sync_len; m_hb = h_back_len; m_ha = h_act_len; m_hf = h_front_len;
    m_vs = v_sync_len; m_vb = v_back_len; m_va = v_act_len; m_vf = v_front_len;
    m_le = lend_en;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s = 0;
      m_hs = 0; m_hb = 0; m_ha = 0; m_hf = 0; m_vs = 0; m_vb = 0; m_va = 0; m_vf = 0; m_le = 0;
    end else if (!vid_en) begin
      s = 0;
      take_geometry();
    end else begin
      int p, lh, vt;
      p  = period();
      lh = m_hs + m_hb + m_ha + m_hf + 4;
      vt = m_vs + m_vb + m_va + m_vf + 4;
      if ((s % p) == p - 1 && (s / p) == lh * vt - 1) begin
        s = 0;
        take_geometry();
      end else begin
        s = s + 1;
      end
    end
  end

  function automatic int seg(input int q, input int a, input int b, input int c);
    if (q <= a) return 0;
    if (q <= a + b + 1) return 1;
    if (q <= a + b + c + 2) return 2;
    return 3;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int p, cv, lh, n, h, v, hp, vp, hx, vy, m;
      bit en, de, tk;
      p  = period();
      cv = p / 2 - 1;
      lh = m_hs + m_hb + m_ha + m_hf + 4;
      n  = s / p;
      m  = s % p;
      h  = n % lh;
      v  = n / lh;
      hp = seg(h, m_hs, m_hb, m_ha);
      vp = seg(v, m_vs, m_vb, m_va);
      hx = h - (m_hs + m_hb + 2);
      vy = v - (m_vs + m_vb + 2);
      en = vid_en;
      de = en && hp == 2 && vp == 2;
      tk = en && m == p - 1;
      chk("R1", "pclk_o", pclk_o, (en && m > cv) ^ edge_sel);
      chk("R2", "hsync_o", hsync_o, (en && hp == 0) ^ inv_hsync);
      chk("R3", "vsync_o", vsync_o, (en && vp == 0) ^ inv_vsync);
      chk("R4", "hstat_o", hstat_o, hp);
      chk("R4", "vstat_o", vstat_o, vp);
      chk("R5", "line_cnt_o", line_cnt_o, (vp < 2) ? m_va : (vp == 2 ? m_va - vy : 0));
      chk("R6", "de_o", de_o, de ^ inv_de);
      chk("R6", "pix_stb_o", pix_stb_o, tk && de);
      chk("R6", "x_o", x_o, (hp == 2) ? hx : 0);
      chk("R6", "y_o", y_o, (vp == 2) ? vy : 0);
      chk("R7", "pix_o", pix_o, (de ? pix_in : '0) ^ {PIX_W{inv_data}});
      chk("R8", "lend_o", lend_o, (en && m_le && h == lh - 1) ^ inv_lend);
    end
  end

  task automatic at_drive();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(1ms);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hs_cnt, vs_cnt, stb_cnt, prev, rise_a, rise_b, idx;
    rst_n = 0; vid_en = 0; edge_sel = 0; lend_en = 1; clk_div = 1;
    inv_hsync = 0; inv_vsync = 0; inv_de = 0; inv_lend = 0; inv_data = 0;
    h_sync_len = 1; h_back_len = 2; h_act_len = 7; h_front_len = 1;
    v_sync_len = 0; v_back_len = 1; v_act_len = 3; v_front_len = 1;
    pix_in = 12'h5A3;
    repeat (3) @(negedge clk);
    scen = "reset";
    chk("R9", "reset hsync_o", hsync_o, 0);
    chk("R9", "reset de_o", de_o, 0);
    chk("R9", "reset pclk_o", pclk_o, 0);
    chk("R4", "reset hstat_o", hstat_o, 0);
    chk("R5", "reset line_cnt_o", line_cnt_o, 0);
    at_drive(); rst_n = 1;
    repeat (4) at_drive();

    // frame 15 pixels x 9 lines, 4 clocks per pixel
    scen = "basic";
    vid_en = 1;
    hs_cnt = 0; vs_cnt = 0; stb_cnt = 0;
    for (int i = 0; i < 540; i++) begin
      @(negedge clk);
      if (i < 60 && hsync_o) hs_cnt++;
      if (vsync_o) vs_cnt++;
      if (pix_stb_o) stb_cnt++;
    end
    chk("R2", "hsync clocks per line", hs_cnt, 2 * 4);
    chk("R3", "vsync clocks per frame", vs_cnt, 1 * 15 * 4);
    chk("R6", "strobes per frame", stb_cnt, 8 * 4);
    repeat (700) at_drive();

    // mid-frame reprogramming must wait for the frame boundary
    scen = "R10 reprogram";
    repeat (137) at_drive();
    h_act_len = 4; v_act_len = 2; lend_en = 0;
    @(negedge clk);
    chk("R10", "line_cnt_o after write", line_cnt_o != 2 || vstat_o == 2'b10, 1);
    repeat (1400) at_drive();

    // disable with polarity inverted
    scen = "inverted";
    inv_hsync = 1; inv_vsync = 1; inv_de = 1; inv_lend = 1; inv_data = 1; edge_sel = 1;
    lend_en = 1;
    repeat (50) at_drive();
    vid_en = 0;
    @(negedge clk);
    chk("R9", "idle hsync_o", hsync_o, 1);
    chk("R9", "idle vsync_o", vsync_o, 1);
    chk("R9", "idle lend_o", lend_o, 1);
    chk("R7", "idle pix_o", pix_o, 12'hFFF);
    chk("R9", "idle pclk_o", pclk_o, 1);
    at_drive();
    clk_div = 3;
    at_drive();
    vid_en = 1;
    repeat (1600) at_drive();

    // divide value 0 acts as 1, restart from sync
    scen = "div0";
    vid_en = 0;
    at_drive();
    inv_hsync = 0; inv_vsync = 0; inv_de = 0; inv_lend = 0; inv_data = 0; edge_sel = 0;
    clk_div = 0;
    at_drive();
    vid_en = 1;
    @(negedge clk);
    chk("R9", "restart hsync_o", hsync_o, 1);
    chk("R9", "restart vstat_o", vstat_o, 0);
    prev = pclk_o; rise_a = -1; rise_b = -1; idx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      idx++;
      if (pclk_o && !prev) begin
        if (rise_a < 0) rise_a = idx;
        else if (rise_b < 0) rise_b = idx;
      end
      prev = pclk_o;
    end
    chk("R1", "pclk rise spacing", rise_b - rise_a, 4);
    repeat (900) at_drive();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule